// File: doc/BRIEF.md
# I2C Master Command Queue Sequencer

This block turns a queue of 11-bit command words into the sequence of bus operations that an I2C master byte/bit engine carries out. Software, or another agent, pushes command words into a transmit command FIFO. The sequencer pulls them one at a time and asks the engine for the right operation:
- a START or repeated START condition,
- one or two address bytes,
- a data write,
- a data read,
- a STOP condition.

Bytes received from the bus are placed in a receive FIFO for the host to pop. Each command word carries its own repeated-start, stop and read/write flags, so the command stream alone describes a whole multi-message transaction.

A configuration input sets the target address, selects 10-bit addressing, clears either FIFO and sets the two FIFO level thresholds. The block raises these events:
- transfer complete,
- transfer error,
- FIFO error,
- RX almost-full,
- TX almost-empty.

SCL timing and the bit-level bus signalling live in the engine behind the `eng_*` handshake.

The controller is a state machine with seven states:
- **Idle** waits for a command. It moves to Start if no transaction is open or the head command asks for a repeated start. Otherwise it moves to Byte.
- **Start** issues START or RESTART, then moves to Address-high.
- **Address-high** sends the 7-bit address byte, or the first 10-bit header byte. On a NACK it moves to Flush. Otherwise it moves to Address-low (10-bit mode) or to Byte.
- **Address-low** sends the low address byte of a 10-bit address, then moves to Byte, or to Flush on a NACK.
- **Byte** writes or reads one data byte and pops the command. It moves to Stop if the command has the stop flag. It moves to Flush on a write NACK. Otherwise it returns to Idle.
- **Flush** discards queued commands until the FIFO is empty, then moves to Stop.
- **Stop** issues STOP and returns to Idle.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A command word holds write data in bits [7:0], a read flag in bit 8 (1 = read one byte), a stop-after flag in bit 9 and a repeated-start-before flag in bit 10. For a read command the data field is ignored: the engine is handed byte 0x00.
- R2: The first command of a transaction causes a START operation, then an address byte {addr[6:0], rd} in 7-bit mode, where rd is the head command's read flag.
- R3: With 10-bit addressing enabled, the address phase is two write operations: {5'b11110, addr[9:8], rd}, then addr[7:0].
- R4: A command with the repeated-start flag inside an open transaction causes a RESTART operation, then the address phase again, with the direction taken from that command's read flag.
- R5: A read command pushes the engine's received byte into the RX FIFO. The read is answered with NACK (eng_nack=1) when the command has the stop flag, and with ACK otherwise.
- R6: A command with the stop flag is followed by a STOP operation. After a STOP that ends an error-free transaction, ev_done pulses for exactly one cycle.
- R7: A NACK (eng_ack=0) on an address byte or a write byte pulses ev_xfer_err, discards every queued command and issues a STOP. ev_done does not pulse for that transaction.
- R8: Both FIFOs hold FIFO_DEPTH entries (default 64). A push into a full TX FIFO is dropped and sets a sticky TX write error. A cfg_tx_clr pulse empties the TX FIFO and clears its error flags.
- R9: Popping an empty RX FIFO sets a sticky RX read error. A received byte that finds the RX FIFO full is dropped and sets a sticky RX write error. A cfg_rx_clr pulse empties the RX FIFO and clears both flags.
- R10: fifo_status reports RX read error in bit 0, RX write error in bit 1, RX empty in bit 3, TX read error in bit 6, TX write error in bit 7 and TX full in bit 11; all other bits are 0. ev_fifo_err is the OR of the four error flags.
- R11: ev_rx_af is high while the RX count is at least cfg_rx_af_lvl. ev_tx_ae is high while the TX count is at most cfg_tx_ae_lvl.
- R12: Each engine operation is requested by exactly one eng_go cycle, and the next request follows its eng_done. Operation codes are START=0, RESTART=1, WRITE=2, READ=3, STOP=4.
- R13: After reset both FIFOs are empty, all error flags are clear, no operation is requested and no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Push cmd_word into the TX command FIFO |
| cmd_word | input | 11 | Command word (R1 layout) |
| rx_pop | input | 1 | Pop one byte from the RX FIFO |
| rx_data | output | 8 | Byte at the head of the RX FIFO |
| cfg_addr | input | 10 | Target address |
| cfg_ten_bit | input | 1 | Select 10-bit addressing |
| cfg_rx_clr | input | 1 | Clear pulse for RX FIFO and its flags |
| cfg_tx_clr | input | 1 | Clear pulse for TX FIFO and its flags |
| cfg_rx_af_lvl | input | LVL_W | RX almost-full threshold |
| cfg_tx_ae_lvl | input | LVL_W | TX almost-empty threshold |
| fifo_status | output | 12 | FIFO status word (R10 layout) |
| ev_done | output | 1 | Transfer-complete pulse |
| ev_xfer_err | output | 1 | Transfer-error pulse |
| ev_fifo_err | output | 1 | Any sticky FIFO error flag set |
| ev_rx_af | output | 1 | RX almost-full level |
| ev_tx_ae | output | 1 | TX almost-empty level |
| eng_go | output | 1 | Operation request strobe |
| eng_op | output | 3 | Operation code (R12) |
| eng_byte | output | 8 | Byte to send for WRITE operations |
| eng_nack | output | 1 | Answer the READ with NACK |
| eng_done | input | 1 | Engine finished the requested operation |
| eng_ack | input | 1 | Slave acknowledged the written byte |
| eng_rdata | input | 8 | Byte received by a READ |

## Verification
A push or pop is visible in fifo_status and in the level events at the first clock edge after the input is sampled. An eng_go appears in the cycle after the state change that needs it. The data of a read is in the RX FIFO one edge after eng_done. ev_done and ev_xfer_err appear one edge after the eng_done that caused them.

The bench drives every input on the falling edge and samples every output on a later falling edge. Its engine model answers each request a fixed two falling edges later. It stalls the sequencer on the START operation while it fills the queue, so that FIFO levels and overflow are checked in a known state. Whole transactions are judged only after an idle gap longer than the longest operation chain they can produce.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    // Command word as held in the TX FIFO: bit 10 restart, 9 stop, 8 read
    typedef struct packed {
        logic       rs;
        logic       stop;
        logic       rd;
        logic [7:0] data;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_BYTE,
        ST_FLUSH,
        ST_STOP
    } seq_st_e;

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty,
    output logic                       wr_err,
    output logic                       rd_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp     <= '0;
            rp     <= '0;
            cnt    <= '0;
            wr_err <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
            if (push && full) wr_err <= 1'b1;
            if (pop && empty) rd_err <= 1'b1;
        end
    end

    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> wr_err);

    assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !clr) |=> rd_err);

endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
    import i2cq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_t       head,
    input  logic       head_empty,
    output logic       head_pop,
    output logic       rx_push,
    output logic [7:0] rx_byte,
    input  logic [9:0] tgt_addr,
    input  logic       ten_bit,
    output logic       eng_go,
    output op_e        eng_op,
    output logic [7:0] eng_byte,
    output logic       eng_nack,
    input  logic       eng_done,
    input  logic       eng_ack,
    input  logic [7:0] eng_rdata,
    output logic       ev_done,
    output logic       ev_xfer_err
);
    seq_st_e st_q, st_d;
    logic    issued_q, in_txn_q, in_txn_d, err_q, err_d, nack_hit;
    logic    op_state, step;

    assign op_state = (st_q == ST_START) || (st_q == ST_ADR_HI) ||
                      (st_q == ST_ADR_LO) || (st_q == ST_BYTE) || (st_q == ST_STOP);
    assign step     = op_state && issued_q && eng_done;

    // next-state logic
    always_comb begin
        st_d     = st_q;
        in_txn_d = in_txn_q;
        err_d    = err_q;
        nack_hit = 1'b0;
        unique case (st_q)
            ST_IDLE:
                if (!head_empty) st_d = (!in_txn_q || head.rs) ? ST_START : ST_BYTE;
            ST_START:
                if (step) begin
                    st_d     = ST_ADR_HI;
                    in_txn_d = 1'b1;
                end
            ST_ADR_HI:
                if (step) begin
                    if (!eng_ack) begin
                        nack_hit = 1'b1;
                        err_d    = 1'b1;
                        st_d     = ST_FLUSH;
                    end else if (ten_bit) st_d = ST_ADR_LO;
                    else st_d = head_empty ? ST_IDLE : ST_BYTE;
                end
            ST_ADR_LO:
                if (step) begin
                    if (!eng_ack) begin
                        nack_hit = 1'b1;
                        err_d    = 1'b1;
                        st_d     = ST_FLUSH;
                    end else st_d = head_empty ? ST_IDLE : ST_BYTE;
                end
            ST_BYTE:
                if (step) begin
                    if (!head.rd && !eng_ack) begin
                        nack_hit = 1'b1;
                        err_d    = 1'b1;
                        st_d     = ST_FLUSH;
                    end else st_d = head.stop ? ST_STOP : ST_IDLE;
                end
            ST_FLUSH:
                if (head_empty) st_d = ST_STOP;
            ST_STOP:
                if (step) begin
                    st_d     = ST_IDLE;
                    in_txn_d = 1'b0;
                    err_d    = 1'b0;
                end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            issued_q    <= 1'b0;
            in_txn_q    <= 1'b0;
            err_q       <= 1'b0;
            ev_done     <= 1'b0;
            ev_xfer_err <= 1'b0;
        end else begin
            st_q        <= st_d;
            in_txn_q    <= in_txn_d;
            err_q       <= err_d;
            issued_q    <= eng_go ? 1'b1 : (step ? 1'b0 : issued_q);
            ev_done     <= (st_q == ST_STOP) && step && !err_q;
            ev_xfer_err <= nack_hit;
        end
    end

    // outputs
    always_comb begin
        eng_go   = op_state && !issued_q;
        eng_op   = OP_STOP;
        eng_byte = 8'h00;
        eng_nack = 1'b0;
        head_pop = 1'b0;
        rx_push  = 1'b0;
        rx_byte  = eng_rdata;
        unique case (st_q)
            ST_START:  eng_op = in_txn_q ? OP_RESTART : OP_START;
            ST_ADR_HI: begin
                eng_op   = OP_WRITE;
                eng_byte = ten_bit ? {5'b11110, tgt_addr[9:8], head.rd}
                                   : {tgt_addr[6:0], head.rd};
            end
            ST_ADR_LO: begin
                eng_op   = OP_WRITE;
                eng_byte = tgt_addr[7:0];
            end
            ST_BYTE: begin
                eng_op   = head.rd ? OP_READ : OP_WRITE;
                eng_byte = head.rd ? 8'h00 : head.data;
                eng_nack = head.rd && head.stop;
                head_pop = step;
                rx_push  = step && head.rd;
            end
            ST_FLUSH:  head_pop = !head_empty;
            ST_STOP:   eng_op = OP_STOP;
            default:   eng_op = OP_STOP;
        endcase
    end

    assert_one_go_per_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |=> !eng_go);

    assert_done_excludes_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_done && ev_xfer_err));

    assert_pop_only_queued_R7: assert property (@(posedge clk) disable iff (!rst_n)
        head_pop |-> !head_empty);

endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
    import i2cq_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int LVL_W      = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_push,
    input  logic [10:0]       cmd_word,
    input  logic              rx_pop,
    output logic [7:0]        rx_data,
    input  logic [9:0]        cfg_addr,
    input  logic              cfg_ten_bit,
    input  logic              cfg_rx_clr,
    input  logic              cfg_tx_clr,
    input  logic [LVL_W-1:0]  cfg_rx_af_lvl,
    input  logic [LVL_W-1:0]  cfg_tx_ae_lvl,
    output logic [11:0]       fifo_status,
    output logic              ev_done,
    output logic              ev_xfer_err,
    output logic              ev_fifo_err,
    output logic              ev_rx_af,
    output logic              ev_tx_ae,
    output logic              eng_go,
    output logic [2:0]        eng_op,
    output logic [7:0]        eng_byte,
    output logic              eng_nack,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [7:0]        eng_rdata
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [CMD_W-1:0] tx_rdata;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, tx_wr_err, tx_rd_err;
    logic             rx_full, rx_empty, rx_wr_err, rx_rd_err;
    logic             head_pop, rx_push;
    logic [7:0]       rx_byte;
    cmd_t             head;
    op_e              op_w;

    assign head = cmd_t'(tx_rdata);

    i2cq_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(cfg_tx_clr),
        .push(cmd_push), .wdata(cmd_word), .pop(head_pop), .rdata(tx_rdata),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .wr_err(tx_wr_err), .rd_err(tx_rd_err)
    );

    i2cq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(cfg_rx_clr),
        .push(rx_push), .wdata(rx_byte), .pop(rx_pop), .rdata(rx_data),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .wr_err(rx_wr_err), .rd_err(rx_rd_err)
    );

    i2cq_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .head(head), .head_empty(tx_empty), .head_pop(head_pop),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .tgt_addr(cfg_addr), .ten_bit(cfg_ten_bit),
        .eng_go(eng_go), .eng_op(op_w), .eng_byte(eng_byte), .eng_nack(eng_nack),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .ev_done(ev_done), .ev_xfer_err(ev_xfer_err)
    );

    assign eng_op      = op_w;
    assign fifo_status = {tx_full, 3'b000, tx_wr_err, tx_rd_err, 2'b00,
                          rx_empty, 1'b0, rx_wr_err, rx_rd_err};
    assign ev_fifo_err = rx_rd_err | rx_wr_err | tx_rd_err | tx_wr_err;
    assign ev_rx_af    = (rx_cnt >= {1'b0, cfg_rx_af_lvl});
    assign ev_tx_ae    = (tx_cnt <= {1'b0, cfg_tx_ae_lvl});

    assert_rx_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !cfg_rx_clr && !rx_pop) |=> rx_full && rx_wr_err);

endmodule

// File: tb/tb_i2c_cmd_sequencer.sv
module tb_i2c_cmd_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LW         = 3;
    localparam int O_ST = 0, O_RS = 1, O_WR = 2, O_RD = 3, O_SP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_push = 1'b0;
    logic [10:0]   cmd_word = '0;
    logic          rx_pop = 1'b0;
    logic [7:0]    rx_data;
    logic [9:0]    cfg_addr = '0;
    logic          cfg_ten_bit = 1'b0;
    logic          cfg_rx_clr = 1'b0;
    logic          cfg_tx_clr = 1'b0;
    logic [LW-1:0] cfg_rx_af_lvl = 3'd3;
    logic [LW-1:0] cfg_tx_ae_lvl = 3'd0;
    logic [11:0]   fifo_status;
    logic          ev_done, ev_xfer_err, ev_fifo_err, ev_rx_af, ev_tx_ae;
    logic          eng_go, eng_nack;
    logic [2:0]    eng_op;
    logic [7:0]    eng_byte;
    logic          eng_done = 1'b0;
    logic          eng_ack = 1'b1;
    logic [7:0]    eng_rdata = '0;

    i2c_cmd_sequencer #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_word(cmd_word),
        .rx_pop(rx_pop), .rx_data(rx_data), .cfg_addr(cfg_addr),
        .cfg_ten_bit(cfg_ten_bit), .cfg_rx_clr(cfg_rx_clr), .cfg_tx_clr(cfg_tx_clr),
        .cfg_rx_af_lvl(cfg_rx_af_lvl), .cfg_tx_ae_lvl(cfg_tx_ae_lvl),
        .fifo_status(fifo_status), .ev_done(ev_done), .ev_xfer_err(ev_xfer_err),
        .ev_fifo_err(ev_fifo_err), .ev_rx_af(ev_rx_af), .ev_tx_ae(ev_tx_ae),
        .eng_go(eng_go), .eng_op(eng_op), .eng_byte(eng_byte), .eng_nack(eng_nack),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_errs = 0;
    int lg_op[512], lg_byte[512], lg_nack[512];
    int lg_n = 0, cur = 0, cnt = 0;
    bit busy = 1'b0;
    int hold = 0, nack_idx = -1;
    int n_done = 0, n_xerr = 0;
    int ex_op[64], ex_byte[64], ex_nack[64];
    int ex_n = 0, base = 0, d0 = 0, x0 = 0;

    // engine model: answers each request two falling edges later
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (!rst_n) busy = 1'b0;
        else if (busy) begin
            if (hold == 0) begin
                if (cnt == 0) begin
                    eng_done  = 1'b1;
                    eng_ack   = (cur != nack_idx);
                    eng_rdata = 8'(8'h30 + cur);
                    busy      = 1'b0;
                end else cnt--;
            end
        end else if (eng_go) begin
            lg_op[lg_n]   = int'(eng_op);
            lg_byte[lg_n] = int'(eng_byte);
            lg_nack[lg_n] = int'(eng_nack);
            cur  = lg_n;
            lg_n++;
            busy = 1'b1;
            cnt  = 1;
        end
    end

    always @(negedge clk) begin
        if (ev_done) n_done++;
        if (ev_xfer_err) n_xerr++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ex_clear(); ex_n = 0; endtask
    task automatic ex_add(input int op, input int b, input int nk);
        ex_op[ex_n] = op; ex_byte[ex_n] = b; ex_nack[ex_n] = nk; ex_n++;
    endtask

    task automatic cmp_log(input string tag);
        chk(lg_n - base == ex_n, {tag, " op count"}, lg_n - base, ex_n);
        for (int i = 0; i < ex_n; i++) begin
            int a, e;
            e = ex_op[i] * 4096 + ex_byte[i] * 16 + ex_nack[i];
            a = (i < lg_n - base) ?
                lg_op[base+i] * 4096 + lg_byte[base+i] * 16 + lg_nack[base+i] : -1;
            chk(a == e, {tag, " op"}, a, e);
        end
    endtask

    task automatic mark();
        @(posedge clk);
        hold = 1; base = lg_n; d0 = n_done; x0 = n_xerr;
    endtask
    task automatic release_eng(); @(posedge clk); hold = 0; endtask
    task automatic idle(input int n); repeat (n) @(negedge clk); endtask
    task automatic push(input int w);
        @(negedge clk); cmd_push = 1'b1; cmd_word = 11'(w);
        @(negedge clk); cmd_push = 1'b0;
    endtask
    task automatic pop_rx(output int v);
        @(negedge clk); v = int'(rx_data); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask
    task automatic clr_rx(); @(negedge clk); cfg_rx_clr = 1'b1; @(negedge clk); cfg_rx_clr = 1'b0; endtask
    task automatic clr_tx(); @(negedge clk); cfg_tx_clr = 1'b1; @(negedge clk); cfg_tx_clr = 1'b0; endtask

    function automatic int adr7(input int a, input int rd);
        return ((a & 'h7F) << 1) | rd;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        int v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R13 reset state
        chk(fifo_status == 12'h008, "R13 status after reset", fifo_status, 12'h008);
        chk(eng_go == 1'b0, "R13 no request", eng_go, 0);
        chk(ev_tx_ae == 1'b1 && ev_rx_af == 1'b0, "R13 levels", {ev_tx_ae, ev_rx_af}, 2);
        chk(ev_fifo_err == 1'b0 && ev_done == 1'b0, "R13 events", {ev_fifo_err, ev_done}, 0);

        // R2 R3 R6 R12 sweep: both address modes, 1..4 write bytes
        for (int ten = 0; ten < 2; ten++) begin
            for (int n = 1; n <= 4; n++) begin
                int adr;
                adr = (ten != 0) ? ('h3A5 - n) : ('h50 + n);
                cfg_addr = 10'(adr); cfg_ten_bit = ten[0];
                mark();
                ex_clear();
                ex_add(O_ST, 0, 0);
                if (ten != 0) begin
                    ex_add(O_WR, 'hF0 | (((adr >> 8) & 3) << 1), 0);
                    ex_add(O_WR, adr & 'hFF, 0);
                end else ex_add(O_WR, adr7(adr, 0), 0);
                for (int k = 0; k < n; k++) begin
                    push(((k == n - 1) ? 512 : 0) + 'h40 + n * 4 + k);
                    ex_add(O_WR, 'h40 + n * 4 + k, 0);
                end
                ex_add(O_SP, 0, 0);
                release_eng(); idle(150);
                cmp_log((ten != 0) ? "R3 R12 ten-bit write" : "R2 R12 seven-bit write");
                chk(n_done - d0 == 1, "R6 done pulse count", n_done - d0, 1);
            end
        end

        // R1 R4 R5 restart read: W 05, Sr|R (data EE ignored), R|stop (data FF ignored)
        cfg_addr = 10'h03C; cfg_ten_bit = 1'b0;
        mark();
        push('h005); push('h5EE); push('h3FF);
        ex_clear();
        ex_add(O_ST, 0, 0); ex_add(O_WR, adr7('h3C, 0), 0); ex_add(O_WR, 'h05, 0);
        ex_add(O_RS, 0, 0); ex_add(O_WR, adr7('h3C, 1), 0);
        ex_add(O_RD, 0, 0); ex_add(O_RD, 0, 1); ex_add(O_SP, 0, 0);
        release_eng(); idle(150);
        cmp_log("R1 R4 R5 restart read");
        chk(n_done - d0 == 1, "R6 done after read", n_done - d0, 1);
        pop_rx(v); chk(v == ((base + 5 + 'h30) & 'hFF), "R5 first rx byte", v, (base + 5 + 'h30) & 'hFF);
        pop_rx(v); chk(v == ((base + 6 + 'h30) & 'hFF), "R5 second rx byte", v, (base + 6 + 'h30) & 'hFF);
        chk(fifo_status[3] == 1'b1, "R10 rx empty bit", fifo_status, 'h008);

        // R7 address NACK
        mark();
        nack_idx = base + 1;
        push('h011); push('h012); push('h213);
        ex_clear(); ex_add(O_ST, 0, 0); ex_add(O_WR, adr7('h3C, 0), 0); ex_add(O_SP, 0, 0);
        release_eng(); idle(150);
        cmp_log("R7 address nack");
        chk(n_xerr - x0 == 1 && n_done == d0, "R7 error not done", n_xerr - x0, 1);
        chk(ev_tx_ae == 1'b1, "R7 queue flushed", ev_tx_ae, 1);

        // R7 data NACK on first write byte
        mark();
        nack_idx = base + 2;
        push('h021); push('h022); push('h023); push('h224);
        ex_clear(); ex_add(O_ST, 0, 0); ex_add(O_WR, adr7('h3C, 0), 0);
        ex_add(O_WR, 'h21, 0); ex_add(O_SP, 0, 0);
        release_eng(); idle(150);
        cmp_log("R7 data nack");
        chk(n_xerr - x0 == 1 && n_done == d0, "R7 data error", n_xerr - x0, 1);
        chk(ev_tx_ae == 1'b1, "R7 data flush", ev_tx_ae, 1);
        @(posedge clk); nack_idx = -1;

        // R8 R10 TX overflow and clear
        mark();
        for (int i = 0; i < DEPTH + 1; i++) push('h010 + i);
        chk(fifo_status[11] == 1'b1, "R8 R10 tx full bit", fifo_status, 'h888);
        chk(fifo_status[7] == 1'b1 && ev_fifo_err == 1'b1, "R8 tx write error", fifo_status, 'h888);
        clr_tx();
        chk(fifo_status == 12'h008, "R8 tx clear", fifo_status, 'h008);
        chk(ev_tx_ae == 1'b1 && ev_fifo_err == 1'b0, "R8 tx empty after clear", {ev_tx_ae, ev_fifo_err}, 2);
        push('h277);
        ex_clear(); ex_add(O_ST, 0, 0); ex_add(O_WR, adr7('h3C, 0), 0);
        ex_add(O_WR, 'h77, 0); ex_add(O_SP, 0, 0);
        release_eng(); idle(150);
        cmp_log("R8 after clear");

        // R11 TX almost-empty level
        mark();
        cfg_tx_ae_lvl = 3'd2;
        push('h031); push('h032);
        chk(ev_tx_ae == 1'b1, "R11 tx at level", ev_tx_ae, 1);
        push('h233);
        chk(ev_tx_ae == 1'b0, "R11 tx above level", ev_tx_ae, 0);
        release_eng(); idle(150);
        cfg_tx_ae_lvl = 3'd0;
        chk(n_done - d0 == 1, "R6 done after level test", n_done - d0, 1);

        // R9 R11 RX level, overflow, underflow
        mark();
        for (int i = 0; i < 5; i++) push((i == 4) ? 'h300 : 'h100);
        release_eng(); idle(150);
        chk(ev_rx_af == 1'b1, "R11 rx at/above level", ev_rx_af, 1);
        for (int i = 0; i < 3; i++) begin
            pop_rx(v);
            chk(v == ((base + 2 + i + 'h30) & 'hFF), "R5 rx byte order", v, (base + 2 + i + 'h30) & 'hFF);
        end
        chk(ev_rx_af == 1'b0, "R11 rx below level", ev_rx_af, 0);
        mark();
        for (int i = 0; i < 7; i++) push((i == 6) ? 'h300 : 'h100);
        release_eng(); idle(150);
        chk(fifo_status[1] == 1'b1 && ev_fifo_err == 1'b1, "R9 R10 rx write error", fifo_status, 'h002);
        clr_rx();
        chk(fifo_status == 12'h008, "R9 rx clear", fifo_status, 'h008);
        pop_rx(v);
        chk(fifo_status[0] == 1'b1 && ev_fifo_err == 1'b1, "R9 R10 rx read error", fifo_status, 'h009);
        clr_rx();
        chk(fifo_status == 12'h008 && ev_fifo_err == 1'b0, "R9 rx read error cleared", fifo_status, 'h008);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule